// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the 32-bit status/control word that sits beside a floating-point arithmetic unit. Software loads the word through a write port, and only the writable bits are kept. Two fields of the word drive the arithmetic unit directly: the rounding selection and the denormal flush control.

After each reporting operation the arithmetic unit presents five raw exception indications with a valid strobe. The controller clears the sticky flag field and rebuilds it from those indications alone. It merges them into the cause field and checks the cause against the enable field. If any enabled cause is set, it issues a one-cycle trap request that carries a fixed trap code.

Compares are handled on a separate path. An ordered equal or greater-than relation only sets a single true/false bit. An unordered relation leaves that bit alone and runs the full status update instead. Operations that cannot raise exceptions, such as absolute value and negate, leave everything untouched.

Top module: `fpsr_ctrl`

## Requirements
- R1: A write stores `wr_data & 32'h0005FFFF`. Bit 17 and bits 31:19 always read as zero.
- R2: `round_trunc` is 1 exactly when bits 1:0 of the register equal 2'b01 (round toward zero). Every other value gives 0 (round to nearest even).
- R3: `flush_zero` follows register bit 18.
- R4: A reporting operation replaces flag field 6:2 with `raw_flags` and discards the earlier flag bits. In `raw_flags` and in the flag, enable (11:7) and cause (16:12) fields, the bit order is the same: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid.
- R5: When `raw_flags` is nonzero, the cause field 16:12 becomes its old value ORed with `raw_flags`. Otherwise the cause field is kept.
- R6: The cycle after a reporting operation, `trap_req` is high for one cycle if `raw_flags` was nonzero and the updated cause ANDed with enable is nonzero. `trap_code` reads 12'h120 while `trap_req` is high and reads 0 otherwise.
- R7: A compare uses `op_kind` 2'b10 for equal and 2'b11 for greater-than. `cmp_rel` is 00 less, 01 equal, 10 greater, 11 unordered. An ordered compare sets `tbit` to whether the relation matched, and the register does not change.
- R8: An unordered compare leaves `tbit` unchanged and updates the status as in R4 to R6.
- R9: A quiet operation (`op_kind` 2'b00) does not change the register or `tbit`, and raises no trap. The same holds for any cycle with `op_valid` low.
- R10: A write and an operation in the same cycle: the write is stored and the operation is dropped.
- R11: After reset the register, `tbit` and `trap_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| op_valid | input | 1 | Operation result strobe from the arithmetic unit |
| op_kind | input | 2 | 00 quiet, 01 arithmetic, 10 compare-equal, 11 compare-greater |
| raw_flags | input | 5 | Raw exception indications of the operation |
| cmp_rel | input | 2 | Compare relation: 00 less, 01 equal, 10 greater, 11 unordered |
| fpsr | output | 32 | Current status/control register |
| round_trunc | output | 1 | 1 selects truncation, 0 selects nearest-even |
| flush_zero | output | 1 | Denormal flush-to-zero control |
| tbit | output | 1 | Compare true/false result |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Trap code, 12'h120 during a request |

## Verification
The in-module assertions check several properties on every cycle. Unwritable bits stay zero. Quiet cycles and ordered compares leave the register stable. A reporting operation with no raw indications leaves an empty flag field. A trap request only follows a valid operation and always carries its code. The rounding output is checked after each write. The directed scenarios are the only place where the following are shown: the exact flag and cause values, the sticky nature of the cause field and the trap it keeps arming, the tbit results for each relation, the write taking priority, and the trap pulse dropping after one cycle.

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl #(
  parameter logic [31:0] WR_MASK  = 32'h0005_FFFF,
  parameter logic [11:0] TRAP_VEC = 12'h120
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        op_valid,
  input  logic [1:0]  op_kind,
  input  logic [4:0]  raw_flags,
  input  logic [1:0]  cmp_rel,
  output logic [31:0] fpsr,
  output logic        round_trunc,
  output logic        flush_zero,
  output logic        tbit,
  output logic        trap_req,
  output logic [11:0] trap_code
);
  localparam int FLG_LO = 2;
  localparam int ENA_LO = 7;
  localparam int CAU_LO = 12;
  localparam int DN_BIT = 18;
  localparam logic [1:0] K_QUIET = 2'b00, K_ARITH = 2'b01, K_CEQ = 2'b10, K_CGT = 2'b11;
  localparam logic [1:0] R_EQ = 2'b01, R_GT = 2'b10, R_UN = 2'b11;

  logic [31:0] reg_q, reg_d;
  logic        t_q, t_d, trap_q, trap_d;
  logic        is_cmp, report;
  logic [4:0]  cause_new;

  assign is_cmp = (op_kind == K_CEQ) || (op_kind == K_CGT);
  assign report = op_valid && !wr_en &&
                  ((op_kind == K_ARITH) || (is_cmp && cmp_rel == R_UN));
  assign cause_new = reg_q[CAU_LO +: 5] | raw_flags;

  always_comb begin
    reg_d  = reg_q;
    t_d    = t_q;
    trap_d = 1'b0;
    if (wr_en) begin
      reg_d = wr_data & WR_MASK;
    end else if (report) begin
      reg_d[FLG_LO +: 5] = raw_flags;
      reg_d[CAU_LO +: 5] = cause_new;
      trap_d = (|raw_flags) && (|(cause_new & reg_q[ENA_LO +: 5]));
    end else if (op_valid && is_cmp) begin
      t_d = (op_kind == K_CEQ) ? (cmp_rel == R_EQ) : (cmp_rel == R_GT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= '0;
      t_q    <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      t_q    <= t_d;
      trap_q <= trap_d;
    end
  end

  assign fpsr        = reg_q;
  assign round_trunc = (reg_q[1:0] == 2'b01);
  assign flush_zero  = reg_q[DN_BIT];
  assign tbit        = t_q;
  assign trap_req    = trap_q;
  assign trap_code   = trap_q ? TRAP_VEC : 12'h000;

  assert_locked_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fpsr & ~WR_MASK) == 32'h0);

  assert_round_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (round_trunc == ($past(wr_data[1:0]) == 2'b01)));

  assert_empty_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_kind == K_ARITH && raw_flags == 5'd0) |=> (fpsr[6:2] == 5'd0));

  assert_trap_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(op_valid) && trap_code == TRAP_VEC));

  assert_ordered_cmp_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && is_cmp && cmp_rel != R_UN) |=> ($stable(fpsr) && !trap_req));

  assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!op_valid || op_kind == K_QUIET) && !wr_en) |=> ($stable(fpsr) && $stable(tbit) && !trap_req));
endmodule

// File: tb/tb_fpsr_ctrl.sv
module tb_fpsr_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [4:0]  raw_flags = '0;
  logic [1:0]  cmp_rel = 2'b00;
  logic [31:0] fpsr;
  logic        round_trunc, flush_zero, tbit, trap_req;
  logic [11:0] trap_code;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_reg = '0;
  logic        m_t = 1'b0, m_trap = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fpsr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_valid(op_valid), .op_kind(op_kind), .raw_flags(raw_flags), .cmp_rel(cmp_rel),
    .fpsr(fpsr), .round_trunc(round_trunc), .flush_zero(flush_zero), .tbit(tbit),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model(input logic w, input logic [31:0] wd, input logic v,
                       input logic [1:0] k, input logic [4:0] rf, input logic [1:0] rel);
    logic rep, cmp;
    logic [4:0] cn;
    cmp = (k == 2'b10) || (k == 2'b11);
    rep = v && !w && ((k == 2'b01) || (cmp && rel == 2'b11));
    m_trap = 1'b0;
    if (w) m_reg = wd & 32'h0005_FFFF;
    else if (rep) begin
      cn = m_reg[16:12] | rf;
      m_trap = (rf != 0) && ((cn & m_reg[11:7]) != 0);
      m_reg[6:2] = rf;
      m_reg[16:12] = cn;
    end else if (v && cmp)
      m_t = (k == 2'b10) ? (rel == 2'b01) : (rel == 2'b10);
  endtask

  task automatic step(input logic w, input logic [31:0] wd, input logic v,
                      input logic [1:0] k, input logic [4:0] rf, input logic [1:0] rel,
                      input string tag);
    model(w, wd, v, k, rf, rel);
    wr_en = w; wr_data = wd; op_valid = v; op_kind = k; raw_flags = rf; cmp_rel = rel;
    @(negedge clk);
    wr_en = 0; op_valid = 0; raw_flags = 0;
    chk(fpsr, m_reg, {tag, " fpsr"});
    chk(32'(tbit), 32'(m_t), {tag, " tbit"});
    chk(32'(trap_req), 32'(m_trap), {tag, " trap_req"});
    chk(32'(trap_code), m_trap ? 32'h120 : 32'h0, {tag, " trap_code R6"});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 2'b00, 0, 2'b00, tag);
  endtask

  task automatic t_reset;
    chk(fpsr, 0, "R11 reset fpsr");
    chk(32'(tbit), 0, "R11 reset tbit");
    chk(32'(trap_req), 0, "R11 reset trap");
  endtask

  task automatic t_write_mask;
    step(1, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, "R1 all-ones write");
    chk(fpsr, 32'h0005_FFFF, "R1 masked value");
    chk(32'(round_trunc), 0, "R2 mode 11 is nearest");
    chk(32'(flush_zero), 1, "R3 flush set");
    step(1, 32'h0000_0001, 0, 2'b00, 0, 0, "R1 write trunc");
    chk(32'(round_trunc), 1, "R2 mode 01 truncates");
    chk(32'(flush_zero), 0, "R3 flush clear");
    step(1, 32'h0004_0002, 0, 2'b00, 0, 0, "R1 write mode 10");
    chk(32'(round_trunc), 0, "R2 mode 10 is nearest");
    chk(32'(flush_zero), 1, "R3 flush from bit18");
  endtask

  task automatic t_flags;
    step(1, 0, 0, 2'b00, 0, 0, "R1 clear");
    step(0, 0, 1, 2'b01, 5'b00001, 0, "R4 inexact");
    chk(fpsr, 32'h0000_1004, "R5 inexact cause");
    step(0, 0, 1, 2'b01, 5'b00100, 0, "R4 overflow replaces");
    chk(fpsr, 32'h0000_5010, "R5 cause accumulates");
    step(0, 0, 1, 2'b01, 5'b00000, 0, "R4 no raw clears flags");
    chk(fpsr, 32'h0000_5000, "R5 cause kept");
  endtask

  task automatic t_quiet;
    step(0, 0, 1, 2'b00, 5'b11111, 0, "R9 quiet op");
    step(0, 0, 0, 2'b01, 5'b11111, 0, "R9 valid low");
    chk(fpsr, 32'h0000_5000, "R9 register untouched");
  endtask

  task automatic t_trap;
    step(1, 32'h0000_0400, 0, 2'b00, 0, 0, "R1 enable divzero");
    step(0, 0, 1, 2'b01, 5'b01000, 0, "R6 divzero trap");
    chk(fpsr, 32'h0000_8420, "R6 fpsr after trap op");
    idle("R6 trap pulse ends");
    step(0, 0, 1, 2'b01, 5'b00001, 0, "R6 sticky cause trap");
    step(0, 0, 1, 2'b01, 5'b00000, 0, "R6 no raw no trap");
    step(1, 32'h0000_0000, 0, 2'b00, 0, 0, "R1 clear");
    step(0, 0, 1, 2'b01, 5'b10000, 0, "R6 disabled no trap");
  endtask

  task automatic t_compare;
    step(0, 0, 1, 2'b10, 5'b11111, 2'b01, "R7 eq match");
    step(0, 0, 1, 2'b11, 0, 2'b00, "R7 gt with less");
    step(0, 0, 1, 2'b11, 0, 2'b10, "R7 gt match");
    step(0, 0, 1, 2'b10, 0, 2'b10, "R7 eq with greater");
    step(0, 0, 1, 2'b11, 0, 2'b10, "R7 gt match again");
    step(1, 32'h0000_0800, 0, 2'b00, 0, 0, "R1 enable invalid");
    step(0, 0, 1, 2'b10, 5'b10000, 2'b11, "R8 unordered eq");
    chk(32'(tbit), 1, "R8 tbit held");
    step(0, 0, 1, 2'b11, 5'b00000, 2'b11, "R8 unordered gt empty");
  endtask

  task automatic t_priority;
    step(1, 32'h0000_0003, 1, 2'b01, 5'b11111, 0, "R10 write beats arith");
    chk(fpsr, 32'h0000_0003, "R10 write stored");
    step(1, 32'h0000_0000, 1, 2'b10, 0, 2'b00, "R10 write beats compare");
    chk(32'(tbit), 1, "R10 tbit kept");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mask();
    t_flags();
    t_quiet();
    t_trap();
    t_compare();
    t_priority();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule